// File: doc/BRIEF.md
# Character Serializer with Internal Loopback

This block turns a stream of 10-bit transmission characters from the coding layer into a serial bit stream, one bit per bit-clock cycle. It runs entirely on the bit clock and derives a character clock from it by dividing by the character width, so each character-clock period holds exactly one character. The character offered on the parallel input is captured in a holding register at each character boundary. That is the rising edge of the character clock. The previously captured character is moved into a shift register at the same edge, so consecutive characters follow each other with no idle bit between them. Bit 0 of each character leaves first.

A loopback control decides where the serial stream goes. When loopback is off, the serial stream drives the line output and the receive output follows the serial line input. When loopback is on, the receive output carries the block's own serial stream instead, and the line output is pinned high. A bit-0 strobe marks the bit time in which the first bit of each real character is on the serial stream. It lets the surrounding logic, or a bench, find character boundaries.

Top module: `serlb_top`

## Requirements
- R1: `tx_char` is sampled only at the bit-clock edge that ends the last bit time of a character period, which is the edge at which `char_clk` rises. Its value at any other edge has no effect on the serial stream.
- R2: `char_clk` has a period of exactly 10 bit-clock cycles and is high for the first 5 bit times of each character period (bit indices 0 to 4). Its first rising edge is the first clock edge after reset is released.
- R3: Bit 0 of a character is transmitted first. In the character period that follows its capture, bit index k of the period carries bit k of the character. Characters follow each other with no gap.
- R4: While `loop_en` is low, `rx_out` equals `line_in`.
- R5: While `loop_en` is high, `line_out` is 1. While it is low, `line_out` carries the serial stream.
- R6: While `loop_en` is high, `rx_out` carries the serial stream that `line_out` would carry with loopback off.
- R7: During reset, and for the first character period after it is released, the serial stream is idle at 1 and `bit0_strobe` is low.
- R8: `bit0_strobe` is high exactly in the bit time in which bit 0 of a captured character is on the serial stream. It is never high in two adjacent cycles, and once the stream is live it is high every 10 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_char | input | 10 | Parallel transmission character from the coding layer, bit 0 sent first |
| loop_en | input | 1 | 1 routes the serial stream to `rx_out` and pins `line_out` high |
| line_in | input | 1 | Serial bit arriving from the line |
| char_clk | output | 1 | Character clock, bit clock divided by 10 |
| line_out | output | 1 | Serial bit driven toward the line |
| rx_out | output | 1 | Serial bit handed to the receive path |
| bit0_strobe | output | 1 | High in the bit time that carries bit 0 of a character |

## Verification
A divide counter that is off by one shows at once, and on every character. `char_clk` gets the wrong shape, and the strobe arrives one bit early or late. Within one character period every serial bit also lands at the wrong bit index. A wrong shift direction, a wrong fill value, or a wrong load timing in the holding or shift registers corrupts the first character that crosses the boundary, so the fault shows at the line or receive output within two character periods of the cause. A wrong loopback selection shows in the first bit time after `loop_en` changes.

// File: rtl/serlb_pkg.sv
package serlb_pkg;

    // Default character width, in bits.
    localparam int unsigned CHAR_W_DEF = 10;

    // Level the line rests at when no character is live.
    localparam logic IDLE_LVL = 1'b1;

    // Serial stream together with the marker for its first bit.
    typedef struct packed {
        logic ser_bit;
        logic first_bit;
    } ser_stream_t;

    // Width of a counter that holds indices 0 .. n-1.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/serlb_char_timer.sv
module serlb_char_timer
    import serlb_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF,
    localparam int unsigned CW = idx_width(CHAR_W)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          boundary,
    output logic          char_clk,
    output logic [CW-1:0] bit_idx
);
    localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);
    localparam logic [CW-1:0] HALF = CW'(CHAR_W / 2);

    logic [CW-1:0] cnt_q;

    // The counter comes out of reset on the last index, so the first edge
    // after release is a character boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= LAST;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign boundary = (cnt_q == LAST);
    assign char_clk = (cnt_q < HALF);
    assign bit_idx  = cnt_q;
endmodule

// File: rtl/serlb_shifter.sv
module serlb_shifter
    import serlb_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF,
    localparam int unsigned CW = idx_width(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic [CW-1:0]     bit_idx,
    input  logic [CHAR_W-1:0] tx_char,
    output ser_stream_t       stream
);
    logic [CHAR_W-1:0] hold_q;
    logic              hold_vld_q;
    logic [CHAR_W-1:0] shift_q;
    logic              shift_vld_q;

    // Capture at the boundary edge. The shift register takes the previous
    // capture at the same edge, so characters leave back to back.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= {CHAR_W{IDLE_LVL}};
            hold_vld_q  <= 1'b0;
            shift_q     <= {CHAR_W{IDLE_LVL}};
            shift_vld_q <= 1'b0;
        end else if (boundary) begin
            hold_q      <= tx_char;
            hold_vld_q  <= 1'b1;
            shift_q     <= hold_q;
            shift_vld_q <= hold_vld_q;
        end else begin
            shift_q     <= {IDLE_LVL, shift_q[CHAR_W-1:1]};
        end
    end

    assign stream.ser_bit   = shift_q[0];
    assign stream.first_bit = shift_vld_q && (bit_idx == '0);
endmodule

// File: rtl/serlb_loop_mux.sv
module serlb_loop_mux
    import serlb_pkg::*;
(
    input  logic loop_en,
    input  logic ser_bit,
    input  logic line_in,
    output logic line_out,
    output logic rx_out
);
    always_comb begin
        if (loop_en) begin
            line_out = 1'b1;
            rx_out   = ser_bit;
        end else begin
            line_out = ser_bit;
            rx_out   = line_in;
        end
    end
endmodule

// File: rtl/serlb_top.sv
module serlb_top
    import serlb_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] tx_char,
    input  logic              loop_en,
    input  logic              line_in,
    output logic              char_clk,
    output logic              line_out,
    output logic              rx_out,
    output logic              bit0_strobe
);
    localparam int unsigned CW = idx_width(CHAR_W);

    logic          boundary;
    logic [CW-1:0] bit_idx;
    ser_stream_t   stream;

    serlb_char_timer #(.CHAR_W(CHAR_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .char_clk (char_clk),
        .bit_idx  (bit_idx)
    );

    serlb_shifter #(.CHAR_W(CHAR_W)) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .bit_idx  (bit_idx),
        .tx_char  (tx_char),
        .stream   (stream)
    );

    serlb_loop_mux mux_i (
        .loop_en  (loop_en),
        .ser_bit  (stream.ser_bit),
        .line_in  (line_in),
        .line_out (line_out),
        .rx_out   (rx_out)
    );

    assign bit0_strobe = stream.first_bit;
endmodule

// File: rtl/serlb_checker.sv
module serlb_checker #(
    parameter int unsigned CHAR_W = 10
) (
    input logic clk,
    input logic rst,
    input logic loop_en,
    input logic line_in,
    input logic char_clk,
    input logic line_out,
    input logic rx_out,
    input logic bit0_strobe
);
    localparam int unsigned GW = $clog2(2 * CHAR_W + 2) + 1;
    localparam logic [GW-1:0] GMAX = GW'(2 * CHAR_W);

    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic [GW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            seen_q  <= 1'b0;
            since_q <= '0;
        end else begin
            if (bit0_strobe) begin
                gap_q  <= GW'(1);
                seen_q <= 1'b1;
            end else if (gap_q != GMAX) begin
                gap_q <= gap_q + 1'b1;
            end
            if (since_q != GMAX) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R5: the line is pinned high in loopback
    assert_line_high_in_loop_R5: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> line_out);

    // R4: the receive output follows the line outside loopback
    assert_rx_follows_line_R4: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> (rx_out == line_in));

    // R8: the strobe is never high in two adjacent cycles
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        bit0_strobe |=> !bit0_strobe);

    // R8: once the stream is live, strobes are one character period apart
    assert_strobe_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        (bit0_strobe && seen_q) |-> (gap_q == GW'(CHAR_W)));

    // R2: the strobe falls in the high half of the character clock
    assert_strobe_in_high_half_R2: assert property (@(posedge clk) disable iff (rst)
        bit0_strobe |-> char_clk);

    // R2: the character clock stays high for more than one cycle after rising
    assert_char_clk_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(char_clk) |=> char_clk);

    // R7: the first character period after reset is idle with no strobe
    assert_idle_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (since_q <= GW'(CHAR_W)) |-> (!bit0_strobe && line_out));
endmodule

bind serlb_top serlb_checker #(.CHAR_W(CHAR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .loop_en     (loop_en),
    .line_in     (line_in),
    .char_clk    (char_clk),
    .line_out    (line_out),
    .rx_out      (rx_out),
    .bit0_strobe (bit0_strobe)
);

// File: tb/serlb_top_tb_top.sv
module serlb_top_tb_top;
    localparam int W   = 10;
    localparam int NCH = 1030;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] tx_char = '0;
    logic         loop_en = 1'b0;
    logic         line_in = 1'b0;
    logic         char_clk, line_out, rx_out, bit0_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serlb_top #(.CHAR_W(W)) dut_i (
        .clk(clk), .rst(rst), .tx_char(tx_char), .loop_en(loop_en),
        .line_in(line_in), .char_clk(char_clk), .line_out(line_out),
        .rx_out(rx_out), .bit0_strobe(bit0_strobe)
    );

    // Odd multiplier: the first 1024 characters cover every 10-bit value.
    function automatic logic [W-1:0] data_of(input int c);
        return W'(c * 37 + 5);
    endfunction

    task automatic check(input string tag, input int p, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s p=%0d actual=%b expected=%b", tag, p, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: idle state while reset is held
        check("R7 line_out in reset", 0, line_out, 1'b1);
        check("R7 bit0_strobe in reset", 0, bit0_strobe, 1'b0);
        check("R4 rx_out in reset", 0, rx_out, line_in);
        rst = 1'b0;
        tx_char = data_of(0);
        for (int p = 1; p <= (NCH + 1) * W; p++) begin
            int   c;
            int   k;
            logic ser;
            logic lp;
            logic li;
            c = (p - 1) / W;
            k = (p - 1) % W;
            @(posedge clk);
            @(negedge clk);
            lp = ((p / 7) % 3) == 0;
            li = 1'((p * 13) >> 2);
            loop_en = lp;
            line_in = li;
            #1;
            ser = (c == 0) ? 1'b1 : data_of(c - 1)[k];
            // R2: character clock high for bit indices 0..4
            check("R2 char_clk", p, char_clk, (k < W / 2));
            // R8 and R7: strobe only at bit 0 of a live character
            check(c == 0 ? "R7 bit0_strobe idle" : "R8 bit0_strobe", p,
                  bit0_strobe, (k == 0) && (c >= 1));
            if (lp) begin
                check("R5 line_out in loopback", p, line_out, 1'b1);
                check("R6 rx_out in loopback (R1/R3 data)", p, rx_out, ser);
            end else begin
                check(c == 0 ? "R7 line_out idle" : "R3 line_out data (R1 capture)",
                      p, line_out, ser);
                check("R4 rx_out from line", p, rx_out, li);
            end
            // Next edge: the real character only at the boundary edge, junk otherwise (R1)
            if (p % W == 0) tx_char = data_of(p / W);
            else            tx_char = ~data_of(p / W) ^ W'(p);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule